// File: doc/BRIEF.md
# Character Panel Row Scan Generator

This block drives the multiplexed row scan of a dot-matrix character panel that has eight 5-pixel-wide character cells per row. It picks how many common lines are active from the line-count and font-height settings. For every common period it walks across the cells and asks an external pattern source for one glyph row at a time. It merges in the cursor and the blink effect, and sends the 40 segment bits out serially on a data line with a shift strobe. At the end of the period it pulses a latch strobe. On that pulse the shifted row appears on the parallel segment outputs and the one-hot common register moves to the matching line.

The pattern source sits outside this block. It is a combinational lookup from a display address and a glyph row to five pixel bits. An alternation signal for the drive waveform flips once per frame. A blink phase flips after a fixed number of frames. When the display is switched off, the scan keeps running but all segment data is dark. The serial data and the two strobes can also feed cascaded segment drivers.

Top module: `lcd_scan_gen`

## Requirements
- R1: The number of active commons is 8 in one-line mode with the short font (`two_line`=0, `tall_font`=0), 11 in one-line mode with the tall font, and 16 in two-line mode, where `tall_font` has no effect. Rows are scanned from COM1 upward and wrap back to COM1 after the last active common.
- R2: A common period lasts `LINE_LONG` clocks at 8 or 11 commons and `LINE_SHORT` clocks at 16 commons. This is the spacing between consecutive `seg_latch` pulses.
- R3: Each common period carries exactly 40 one-cycle `seg_shift` pulses, with `seg_d` valid in the same cycle. Segment 39 is sent first and segment 0 last. After the next `seg_latch`, `seg_out` equals the 40 bits sent.
- R4: `seg_latch` is a one-cycle pulse that never coincides with `seg_shift`. `com` and `seg_out` change only in a `seg_latch` cycle, and `com` has at most one bit set.
- R5: Commons above the active count stay 0. After reset `com`, `seg_out` and `m_alt` are 0 until the first latch.
- R6: Segment s shows cell c = s/5 using pattern bit 4-(s%5). The pattern address is c in one-line mode and for rows 0..7 of two-line mode, and 0x40+c for rows 8..15 of two-line mode. The glyph row is the row index, taken modulo 8 in two-line mode.
- R7: When `cursor_on` is 1, the cell whose address equals `cursor_pos` has all 5 pixels of its cursor row forced on. The cursor row is glyph row 7 with the short font and row 10 with the tall font.
- R8: When `blink_on` is 1 and the blink phase is 1, all pixels of the cell at `cursor_pos` are on. The phase starts at 0 after reset. It flips after every `BLINK_FRAMES` complete frames, so frame F (counted from 1) uses phase ((F-1)/`BLINK_FRAMES`) mod 2.
- R9: With `disp_on`=0 every bit sent on `seg_d` is 0, and the common scan keeps running.
- R10: `m_alt` flips exactly on the latch that selects COM1, so it reads F mod 2 during frame F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| two_line | input | 1 | Two-line mode (16 commons) |
| tall_font | input | 1 | Tall font in one-line mode (11 commons) |
| disp_on | input | 1 | Display enable; 0 blanks the segments |
| cursor_on | input | 1 | Underline cursor enable |
| blink_on | input | 1 | Blinking cell enable |
| cursor_pos | input | 7 | Display address of the cursor cell |
| pat_addr | output | 7 | Display address of the cell being fetched |
| pat_row | output | 4 | Glyph row being fetched |
| pat_bits | input | 5 | Pixel bits for pat_addr/pat_row, bit 4 leftmost |
| seg_d | output | 1 | Serial segment data |
| seg_shift | output | 1 | Shift strobe for seg_d |
| seg_latch | output | 1 | Latch strobe at the end of a common period |
| seg_out | output | 40 | Latched segment row |
| com | output | 16 | One-hot common select |
| m_alt | output | 1 | Per-frame drive alternation |

## Verification
The bench sets `LINE_LONG`=60, `LINE_SHORT`=48 and `BLINK_FRAMES`=2. With these values a common period stays longer than the 40-bit shift burst, so the period length is still distinct for each duty. A full 16-common frame takes under 800 clocks. Every latch in every frame of every mode can therefore be compared against an arithmetic model. The blink phase flips several times within the run, so both phases appear under both font heights and in two-line mode.

// File: rtl/lcd_scan_gen.sv
module lcd_scan_gen #(
  parameter int CHARS        = 8,
  parameter int CHAR_W       = 5,
  parameter int LINE_LONG    = 400,
  parameter int LINE_SHORT   = 200,
  parameter int BLINK_FRAMES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    two_line,
  input  logic                    tall_font,
  input  logic                    disp_on,
  input  logic                    cursor_on,
  input  logic                    blink_on,
  input  logic [6:0]              cursor_pos,
  output logic [6:0]              pat_addr,
  output logic [3:0]              pat_row,
  input  logic [CHAR_W-1:0]       pat_bits,
  output logic                    seg_d,
  output logic                    seg_shift,
  output logic                    seg_latch,
  output logic [CHARS*CHAR_W-1:0] seg_out,
  output logic [15:0]             com,
  output logic                    m_alt
);
  localparam int SEGS = CHARS * CHAR_W;
  localparam int CW   = $clog2(LINE_LONG + 1);
  localparam int FW   = $clog2(BLINK_FRAMES + 1);

  logic [CW-1:0]   cnt;
  logic [3:0]      row;
  logic [SEGS-1:0] sr;
  logic [FW-1:0]   fcnt;
  logic            blink_ph;

  wire [4:0]    duty     = two_line ? 5'd16 : (tall_font ? 5'd11 : 5'd8);
  wire [CW-1:0] line_len = two_line ? CW'(LINE_SHORT) : CW'(LINE_LONG);
  wire          line_end = cnt >= line_len - CW'(1);
  wire          shifting = cnt < CW'(SEGS);
  wire          last_row = {1'b0, row} >= duty - 5'd1;

  wire [CW-1:0] seg_idx  = CW'(SEGS - 1) - cnt;
  wire [6:0]    char_idx = 7'(seg_idx / CW'(CHAR_W));
  wire [2:0]    col      = 3'(seg_idx % CW'(CHAR_W));

  assign pat_addr = {two_line & row[3], 6'd0} + char_idx;
  assign pat_row  = two_line ? {1'b0, row[2:0]} : row;

  wire cur_row   = pat_row == ((two_line || !tall_font) ? 4'd7 : 4'd10);
  wire at_cursor = cursor_pos == pat_addr;
  wire pixel     = pat_bits[3'(CHAR_W - 1) - col];
  wire dbit      = disp_on & (pixel | (cursor_on & at_cursor & cur_row)
                                    | (blink_on & at_cursor & blink_ph));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      row       <= '0;
      sr        <= '0;
      fcnt      <= '0;
      blink_ph  <= 1'b0;
      seg_d     <= 1'b0;
      seg_shift <= 1'b0;
      seg_latch <= 1'b0;
      seg_out   <= '0;
      com       <= '0;
      m_alt     <= 1'b0;
    end else begin
      seg_shift <= 1'b0;
      seg_latch <= 1'b0;
      if (line_end) begin
        cnt       <= '0;
        seg_latch <= 1'b1;
        seg_out   <= sr;
        com       <= 16'd1 << row;
        row       <= last_row ? 4'd0 : row + 4'd1;
        if (row == 4'd0) m_alt <= ~m_alt;
        if (last_row) begin
          if (fcnt == FW'(BLINK_FRAMES - 1)) begin
            fcnt     <= '0;
            blink_ph <= ~blink_ph;
          end else begin
            fcnt <= fcnt + FW'(1);
          end
        end
      end else begin
        cnt <= cnt + CW'(1);
        if (shifting) begin
          sr        <= {sr[SEGS-2:0], dbit};
          seg_d     <= dbit;
          seg_shift <= 1'b1;
        end
      end
    end
  end

  AST_COM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com)); // R4
  AST_LATCH_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_latch |-> !seg_shift); // R4
  AST_HOLD_BETWEEN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_latch |-> ($stable(com) && $stable(seg_out))); // R4
  AST_M_AT_COM1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_alt != $past(m_alt)) |-> (seg_latch && com[0])); // R10
  AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_shift && !$past(disp_on)) |-> !seg_d); // R9
endmodule

// File: tb/lcd_scan_gen_tb.sv
module lcd_scan_gen_tb;
  localparam int LL = 60, LS = 48, BF = 2;

  logic clk = 0, rst_n = 0;
  logic two_line = 0, tall_font = 0, disp_on = 1, cursor_on = 0, blink_on = 0;
  logic [6:0] cursor_pos = 0;
  logic [6:0] pat_addr;
  logic [3:0] pat_row;
  logic [4:0] pat_bits;
  logic seg_d, seg_shift, seg_latch, m_alt;
  logic [39:0] seg_out;
  logic [15:0] com;

  int nchk = 0, nerr = 0;
  int ex_row = 0, frame = 0, bcount = 0, cyc = 0, nsh = 0;
  bit seen_first = 0;
  logic [39:0] coll = '0;

  always #2 clk = ~clk;

  function automatic logic [4:0] pat(input int a, input int r);
    return 5'(((a * 7) + (r * 13) + (a >> 2)) ^ r);
  endfunction

  assign pat_bits = pat(int'(pat_addr), int'(pat_row));

  lcd_scan_gen #(.LINE_LONG(LL), .LINE_SHORT(LS), .BLINK_FRAMES(BF)) u_dut (
    .clk(clk), .rst_n(rst_n), .two_line(two_line), .tall_font(tall_font),
    .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on),
    .cursor_pos(cursor_pos), .pat_addr(pat_addr), .pat_row(pat_row),
    .pat_bits(pat_bits), .seg_d(seg_d), .seg_shift(seg_shift),
    .seg_latch(seg_latch), .seg_out(seg_out), .com(com), .m_alt(m_alt));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int duty();
    return two_line ? 16 : (tall_font ? 11 : 8);
  endfunction

  function automatic logic [39:0] model_seg(input int r, input int f);
    logic [39:0] v;
    int curr = (two_line || !tall_font) ? 7 : 10;
    int g = two_line ? r % 8 : r;
    bit ph = ((f - 1) / BF) % 2;
    v = '0;
    for (int s = 0; s < 40; s++) begin
      int c = s / 5;
      int a = (two_line && r >= 8) ? 64 + c : c;
      logic [4:0] p = pat(a, g);
      bit hit = (a == int'(cursor_pos));
      bit b = p[4 - (s % 5)] | (cursor_on & hit & (g == curr)) | (blink_on & hit & ph);
      v[s] = disp_on & b;
    end
    return v;
  endfunction

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (seg_shift) begin coll = {coll[38:0], seg_d}; nsh++; end
    if (seg_latch) begin
      if (ex_row == 0) begin
        frame++;
        chk(m_alt == frame[0], "R10 m_alt per frame", 64'(m_alt), 64'(frame[0]));
      end
      chk(com == 16'(1 << ex_row), "R1 R5 common select", 64'(com), 64'(1 << ex_row));
      chk(seg_out == model_seg(ex_row, frame), "R6 R7 R8 R9 segment row", 64'(seg_out), 64'(model_seg(ex_row, frame)));
      chk(nsh == 40, "R3 shift count", 64'(nsh), 64'd40);
      chk(coll == seg_out, "R3 serial order", 64'(coll), 64'(seg_out));
      if (seen_first)
        chk(cyc == (two_line ? LS : LL), "R2 period length", 64'(cyc), 64'(two_line ? LS : LL));
      seen_first = 1; cyc = 0; nsh = 0; coll = '0;
      if (ex_row == duty() - 1) begin ex_row = 0; bcount++; end
      else ex_row++;
    end
  end

  task automatic run_to(input int target);
    wait (bcount == target);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(com == 0, "R5 reset com", 64'(com), 0);
    chk(seg_out == 0, "R5 reset seg_out", 64'(seg_out), 0);
    chk(m_alt == 0, "R5 reset m_alt", 64'(m_alt), 0);
    chk(seg_latch == 0, "R4 reset latch", 64'(seg_latch), 0);
    run_to(2);
    cursor_on = 1; cursor_pos = 7'd3;                   // R7 short font
    run_to(4);
    tall_font = 1; cursor_pos = 7'd5; blink_on = 1;     // R1 11 commons, R7 row 10, R8
    run_to(7);
    two_line = 1; tall_font = 0; cursor_pos = 7'h42;    // R1 16 commons, R6 second line
    run_to(11);
    tall_font = 1; cursor_pos = 7'd6;                   // R1 tall ignored in two-line
    run_to(13);
    disp_on = 0;                                        // R9 blanking
    run_to(15);
    disp_on = 1; two_line = 0; tall_font = 0; blink_on = 0; cursor_on = 0;
    run_to(16);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule